// File: doc/BRIEF.md
# Re-encode-and-compare bit error estimator

This block sits beside a Viterbi decoder and estimates how many channel bits were received in error, without a known reference sequence. It takes each decoded bit and runs it through a convolutional encoder with the same generator taps as the transmitter. It then compares each re-encoded symbol with the hard decision (sign bit) of the matching received soft symbol. The received hard decisions pass through a delay line so that they meet the decoded bit they belong to. Positions that the depuncturer filled in are left out of the comparison, following the pattern of the selected code rate.

Mismatches are counted over a measurement period, given as a number of decoded bits. A small state machine controls the period. In `ST_ARM` it waits for the first decoded bit of a period, and on that bit it samples the period length and the rate selection. In `ST_COUNT` it counts down the remaining bits. There are four transitions: `ARM_TO_COUNT` (the first bit of a period longer than one), `COUNT_TO_COUNT` (a bit that is not the last), `COUNT_TO_ARM` (the last bit) and `ARM_TO_ARM` (a one-bit period). The running count restarts on the first bit of each period. Its final value is latched when the period ends.

Top module: `ber_reencode_monitor`

## Requirements
- R1: The hard decision of each received soft symbol is its most significant bit, and an encoded 1 corresponds to that bit being set. The first symbol of a vector occupies the most significant field of `rx_sym`. No other bit of a symbol affects the result.
- R2: Decoded bits feed an encoder of constraint length `CONSTR_K`. In each generator, the most significant tap weights the newest bit. The encoder history is zero after reset.
- R3: On every cycle with `in_en` high, a received vector enters a delay line that is `LATENCY` entries deep. A decoded bit is compared with the vector that entered `LATENCY` accepted vectors before the current one.
- R4: Each decoded bit (`dec_valid` high) contributes the number of compared symbols whose hard decision differs from the re-encoded symbol. This number is added to `err_running`, which shows the sum from the next cycle on.
- R5: On the first decoded bit of each period, `err_running` restarts: it takes that bit's error count alone.
- R6: `err_running` saturates at 65535 (all ones) and never wraps.
- R7: On the last decoded bit of a period, `err_latched` takes the final period count, visible from the next cycle on. It holds that value until the next period ends.
- R8: `period_len` and `rate_sel` are sampled only on the first decoded bit of a period. Changing either one mid-period leaves the current period untouched. A period length of 0 acts as 1.
- R9: Rate codes are 0 (unpunctured), 1 (2/3), 2 (3/4), 3 (4/5), 4 (5/6) and 5 (6/7); codes 6 and 7 act as 0. The pattern phase starts at 0 on each period's first bit and advances one column per decoded bit. First symbol keep masks by column: 10, 101, 1000, 10101, 100101. Second symbol keep masks by column: 11, 110, 1111, 11010, 111010. A 0 excludes the symbol. Any further symbols are always compared.
- R10: On cycles with `dec_valid` low, neither count, the encoder history nor the pattern phase changes.
- R11: An asynchronous high `rst` clears both counts, the encoder history and the delay line at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| in_en | input | 1 | A received symbol vector is accepted this cycle |
| rx_sym | input | N_SYM*SOFTW | Received soft symbols, first symbol in the top field |
| dec_valid | input | 1 | The decoder presents a decoded bit this cycle |
| dec_bit | input | 1 | Decoded bit |
| rate_sel | input | 3 | Puncturing rate code |
| period_len | input | PERIOD_W | Measurement period in decoded bits |
| err_running | output | CNT_W | Error count of the period in progress |
| err_latched | output | CNT_W | Error count of the last completed period |

## Verification
The bench sends random data with decoded bits that match the true information. Any misalignment of the delay line, or a wrong tap order in the encoder, then shows up as phantom errors in a period that should be clean. Under each punctured rate, every received symbol has its sign flipped. A wrong column order, a swapped symbol order or a phase that does not restart would then give per-period totals that differ from the masks. The bench writes new period lengths and rates mid-period, and uses lengths of 0 and 1: a design that applied a value early would shift every later boundary. A long error-dense period pushes the count past 65535: a wrapping counter would latch a small value.

// File: rtl/ber_est_pkg.sv
package ber_est_pkg;

    typedef enum logic {
        ST_ARM,
        ST_COUNT
    } meas_state_t;

    localparam int unsigned RATE_W  = 3;
    localparam int unsigned PHASE_W = 3;

    // Number of pattern columns for a rate code
    function automatic logic [PHASE_W-1:0] punct_len(input logic [RATE_W-1:0] rate);
        logic [PHASE_W-1:0] len;
        case (rate)
            3'd1, 3'd2, 3'd3, 3'd4, 3'd5: len = rate + 3'd1;
            default:                      len = 3'd1;
        endcase
        return len;
    endfunction

    // Keep bits for the first two symbols; bit i of each mask is column i
    function automatic logic [1:0] punct_keep(input logic [RATE_W-1:0] rate,
                                              input logic [PHASE_W-1:0] phase);
        logic [7:0] first_m;
        logic [7:0] second_m;
        case (rate)
            3'd1: begin first_m = 8'b0000_0001; second_m = 8'b0000_0011; end
            3'd2: begin first_m = 8'b0000_0101; second_m = 8'b0000_0011; end
            3'd3: begin first_m = 8'b0000_0001; second_m = 8'b0000_1111; end
            3'd4: begin first_m = 8'b0001_0101; second_m = 8'b0000_1011; end
            3'd5: begin first_m = 8'b0010_1001; second_m = 8'b0001_0111; end
            default: begin first_m = 8'hFF; second_m = 8'hFF; end
        endcase
        return {second_m[phase], first_m[phase]};
    endfunction

endpackage

// File: rtl/ber_rx_delay.sv
module ber_rx_delay #(
    parameter int unsigned N_SYM   = 2,
    parameter int unsigned SOFTW   = 3,
    parameter int unsigned LATENCY = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_en,
    input  logic [N_SYM*SOFTW-1:0]   rx_sym,
    output logic [N_SYM-1:0]         hard_tail
);

    logic [N_SYM-1:0] hard_now;
    logic [N_SYM-1:0] line_q [LATENCY];

    // Sign bit of each symbol; symbol 0 sits in the top field
    for (genvar j = 0; j < N_SYM; j++) begin : g_sign
        assign hard_now[j] = rx_sym[(N_SYM-j)*SOFTW-1];
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            for (int i = 0; i < LATENCY; i++) line_q[i] <= '0;
        end else if (in_en) begin
            line_q[0] <= hard_now;
            for (int i = 1; i < LATENCY; i++) line_q[i] <= line_q[i-1];
        end
    end

    assign hard_tail = line_q[LATENCY-1];

    // R3: the line only moves when a vector is accepted
    p_tail_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !in_en |=> $stable(hard_tail));

endmodule

// File: rtl/ber_reencoder.sv
module ber_reencoder #(
    parameter int unsigned N_SYM    = 2,
    parameter int unsigned CONSTR_K = 5,
    parameter int unsigned GEN_A    = 19,
    parameter int unsigned GEN_B    = 29,
    parameter int unsigned GEN_C    = 0,
    parameter int unsigned GEN_D    = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             bit_in,
    output logic [N_SYM-1:0] enc
);

    localparam int unsigned HIST_W = CONSTR_K - 1;

    logic [HIST_W-1:0]   hist_q;
    logic [CONSTR_K-1:0] window;

    // Newest bit at the top, matching the generator's top tap
    assign window = {bit_in, hist_q};

    for (genvar j = 0; j < N_SYM; j++) begin : g_tap
        localparam int unsigned GV = (j == 0) ? GEN_A :
                                     (j == 1) ? GEN_B :
                                     (j == 2) ? GEN_C : GEN_D;
        localparam logic [CONSTR_K-1:0] TAPS = GV[CONSTR_K-1:0];
        assign enc[j] = ^(window & TAPS);
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst)       hist_q <= '0;
        else if (step) hist_q <= window[CONSTR_K-1:1];
    end

    // R10: history frozen without a decoded bit
    p_hist_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(hist_q));

    // R2: the newest history bit is the bit that was just shifted in
    p_hist_newest_r2: assert property (@(posedge clk) disable iff (rst)
        step |=> hist_q[HIST_W-1] == $past(bit_in));

endmodule

// File: rtl/ber_punct_mask.sv
module ber_punct_mask
    import ber_est_pkg::*;
#(
    parameter int unsigned N_SYM = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              restart,
    input  logic [RATE_W-1:0] rate,
    output logic [N_SYM-1:0]  keep
);

    logic [PHASE_W-1:0] phase_q;
    logic [PHASE_W-1:0] phase_eff;
    logic [PHASE_W:0]   phase_inc;
    logic [1:0]         pat;

    assign phase_eff = restart ? '0 : phase_q;
    assign phase_inc = {1'b0, phase_eff} + 1'b1;
    assign pat       = punct_keep(rate, phase_eff);

    for (genvar j = 0; j < N_SYM; j++) begin : g_keep
        if (j < 2) begin : g_pat
            assign keep[j] = pat[j];
        end else begin : g_all
            assign keep[j] = 1'b1;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            phase_q <= '0;
        end else if (step) begin
            if (phase_inc >= {1'b0, punct_len(rate)}) phase_q <= '0;
            else                                      phase_q <= phase_inc[PHASE_W-1:0];
        end
    end

    // R9: within a period the phase stays inside the pattern
    p_phase_range_r9: assert property (@(posedge clk) disable iff (rst)
        (step && !restart) |-> (phase_q < punct_len(rate)));

    // R10: phase frozen without a decoded bit
    p_phase_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(phase_q));

endmodule

// File: rtl/ber_reencode_monitor.sv
module ber_reencode_monitor
    import ber_est_pkg::*;
#(
    parameter int unsigned N_SYM    = 2,
    parameter int unsigned SOFTW    = 3,
    parameter int unsigned CONSTR_K = 5,
    parameter int unsigned GEN_A    = 19,
    parameter int unsigned GEN_B    = 29,
    parameter int unsigned GEN_C    = 0,
    parameter int unsigned GEN_D    = 0,
    parameter int unsigned LATENCY  = 8,
    parameter int unsigned PERIOD_W = 24,
    parameter int unsigned CNT_W    = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_en,
    input  logic [N_SYM*SOFTW-1:0]  rx_sym,
    input  logic                    dec_valid,
    input  logic                    dec_bit,
    input  logic [2:0]              rate_sel,
    input  logic [PERIOD_W-1:0]     period_len,
    output logic [CNT_W-1:0]        err_running,
    output logic [CNT_W-1:0]        err_latched
);

    localparam int unsigned ERR_W = $clog2(N_SYM + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    meas_state_t       state_q, state_d;
    logic [RATE_W-1:0] rate_q;
    logic [RATE_W-1:0] rate_eff;
    logic [PERIOD_W-1:0] rem_q, rem_now, first_len;
    logic [CNT_W-1:0]  run_q, lat_q, run_next, run_base;
    logic [CNT_W:0]    run_wide;
    logic [N_SYM-1:0]  hard_tail, enc, keep, miss;
    logic [ERR_W-1:0]  bit_errs;
    logic              arming, last_bit;

    ber_rx_delay #(
        .N_SYM(N_SYM), .SOFTW(SOFTW), .LATENCY(LATENCY)
    ) u_delay (
        .clk(clk), .rst(rst), .in_en(in_en), .rx_sym(rx_sym), .hard_tail(hard_tail)
    );

    ber_reencoder #(
        .N_SYM(N_SYM), .CONSTR_K(CONSTR_K),
        .GEN_A(GEN_A), .GEN_B(GEN_B), .GEN_C(GEN_C), .GEN_D(GEN_D)
    ) u_enc (
        .clk(clk), .rst(rst), .step(dec_valid), .bit_in(dec_bit), .enc(enc)
    );

    ber_punct_mask #(
        .N_SYM(N_SYM)
    ) u_mask (
        .clk(clk), .rst(rst), .step(dec_valid), .restart(arming),
        .rate(rate_eff), .keep(keep)
    );

    assign arming   = (state_q == ST_ARM);
    assign rate_eff = arming ? rate_sel : rate_q;
    assign miss     = (hard_tail ^ enc) & keep;

    always_comb begin
        bit_errs = '0;
        for (int j = 0; j < N_SYM; j++) bit_errs = bit_errs + ERR_W'(miss[j]);
    end

    assign first_len = (period_len == '0) ? PERIOD_W'(1) : period_len;
    assign rem_now   = arming ? (first_len - 1'b1) : (rem_q - 1'b1);
    assign last_bit  = (rem_now == '0);
    assign run_base  = arming ? '0 : run_q;
    assign run_wide  = {1'b0, run_base} + (CNT_W+1)'(bit_errs);
    assign run_next  = run_wide[CNT_W] ? CNT_MAX : run_wide[CNT_W-1:0];

    // State register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) state_q <= ST_ARM;
        else     state_q <= state_d;
    end

    // Next state: ARM_TO_COUNT, ARM_TO_ARM, COUNT_TO_COUNT, COUNT_TO_ARM
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARM: begin
                if (dec_valid && !last_bit) state_d = ST_COUNT;
            end
            ST_COUNT: begin
                if (dec_valid && last_bit) state_d = ST_ARM;
            end
        endcase
    end

    // Counters and outputs
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            rem_q  <= '0;
            rate_q <= '0;
            run_q  <= '0;
            lat_q  <= '0;
        end else if (dec_valid) begin
            rem_q <= rem_now;
            run_q <= run_next;
            if (arming)   rate_q <= rate_sel;
            if (last_bit) lat_q  <= run_next;
        end
    end

    assign err_running = run_q;
    assign err_latched = lat_q;

    // R10: nothing moves without a decoded bit
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |=> ($stable(err_running) && $stable(err_latched)));

    // R4: inside a period the count never falls
    p_count_grows_r4: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && state_q == ST_COUNT) |=> (err_running >= $past(err_running)));

    // R5: a fresh period starts from one bit's worth of errors
    p_restart_r5: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && state_q == ST_ARM) |=> (err_running <= CNT_W'(N_SYM)));

    // R6: a saturated count stays saturated within the period
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && state_q == ST_COUNT && err_running == CNT_MAX)
            |=> (err_running == CNT_MAX));

    // R7: the latched value only changes right after a period ends
    p_latch_at_end_r7: assert property (@(posedge clk) disable iff (rst)
        (err_latched != $past(err_latched)) |-> (state_q == ST_ARM && $past(dec_valid)));

endmodule

// File: tb/ber_reencode_monitor_tb_top.sv
module ber_reencode_monitor_tb_top;

    localparam int N   = 2;
    localparam int SW  = 3;
    localparam int K   = 5;
    localparam int GA  = 19;
    localparam int GB  = 29;
    localparam int LAT = 4;
    localparam int PW  = 24;
    localparam int CW  = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_en = 1'b0;
    logic [N*SW-1:0] rx_sym = '0;
    logic            dec_valid = 1'b0;
    logic            dec_bit = 1'b0;
    logic [2:0]      rate_sel = '0;
    logic [PW-1:0]   period_len = '0;
    logic [CW-1:0]   err_running, err_latched;

    always #2 clk = ~clk;

    ber_reencode_monitor #(
        .N_SYM(N), .SOFTW(SW), .CONSTR_K(K), .GEN_A(GA), .GEN_B(GB),
        .GEN_C(0), .GEN_D(0), .LATENCY(LAT), .PERIOD_W(PW), .CNT_W(CW)
    ) dut_i (
        .clk(clk), .rst(rst), .in_en(in_en), .rx_sym(rx_sym),
        .dec_valid(dec_valid), .dec_bit(dec_bit), .rate_sel(rate_sel),
        .period_len(period_len), .err_running(err_running), .err_latched(err_latched)
    );

    typedef struct {
        int    run;
        int    lat;
        string req;
    } exp_t;

    exp_t     exp_q[$];
    int       checks = 0;
    int       fails = 0;
    bit       mon_on = 1'b0;
    bit       info[$];
    bit [1:0] flips[$];
    string    cur_req = "R4";
    int       nxt_rate = 0;
    int       nxt_period = 10;

    // reference model state
    bit m_arm = 1'b1;
    int m_rem = 0, m_run = 0, m_lat = 0, m_phase = 0, m_rate = 0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    function automatic int plen(input int rate);
        return (rate >= 1 && rate <= 5) ? rate + 1 : 1;
    endfunction

    // bit 0: first symbol, bit 1: second symbol
    function automatic bit [1:0] keep_of(input int rate, input int phase);
        bit [0:5] a, b;
        case (rate)
            1: begin a = 6'b100000; b = 6'b110000; end
            2: begin a = 6'b101000; b = 6'b110000; end
            3: begin a = 6'b100000; b = 6'b111100; end
            4: begin a = 6'b101010; b = 6'b110100; end
            5: begin a = 6'b100101; b = 6'b111010; end
            default: begin a = 6'b111111; b = 6'b111111; end
        endcase
        return {b[phase], a[phase]};
    endfunction

    function automatic bit enc_sym(input int k, input int gen);
        bit p = 1'b0;
        for (int t = 0; t < K; t++) begin
            if (k - t >= 0 && gen[K-1-t]) p ^= info[k-t];
        end
        return p;
    endfunction

    task automatic model_bit(input bit [1:0] fl);
        bit [1:0] kp;
        int       errs;
        if (m_arm) begin
            m_rate  = nxt_rate;
            m_phase = 0;
            m_rem   = (nxt_period == 0) ? 1 : nxt_period;
            m_run   = 0;
        end
        kp   = keep_of(m_rate, m_phase);
        errs = int'(kp[0] & fl[0]) + int'(kp[1] & fl[1]);
        m_rem--;
        m_run = (m_run + errs > 65535) ? 65535 : m_run + errs;
        m_phase = (m_phase + 1 >= plen(m_rate)) ? 0 : m_phase + 1;
        if (m_rem == 0) begin
            m_lat = m_run;
            m_arm = 1'b1;
        end else begin
            m_arm = 1'b0;
        end
    endtask

    // Driver: one cycle; pushes the values expected after the next edge
    task automatic step(input bit en, input bit [1:0] fl);
        exp_t e;
        @(negedge clk);
        in_en      = en;
        dec_valid  = 1'b0;
        rate_sel   = 3'(nxt_rate);
        period_len = PW'(nxt_period);
        if (en) begin
            int k;
            info.push_back(1'($urandom_range(0, 1)));
            k = info.size() - 1;
            flips.push_back(fl);
            for (int j = 0; j < N; j++) begin
                bit s;
                s = enc_sym(k, (j == 0) ? GA : GB) ^ fl[j];
                // sign carries the decision, low bits are noise
                rx_sym[(N-j)*SW-1 -: SW] = {s, 2'($urandom_range(0, 3))};
            end
            if (k >= LAT) begin
                dec_valid = 1'b1;
                dec_bit   = info[k-LAT];
                model_bit(flips[k-LAT]);
            end
        end
        e.run = m_run;
        e.lat = m_lat;
        e.req = cur_req;
        exp_q.push_back(e);
    endtask

    task automatic finish_period();
        while (!m_arm) step(1'b1, 2'b00);
    endtask

    // Monitor: pops one expectation per driven cycle
    always @(posedge clk) begin
        if (mon_on) begin
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(int'(err_running) == e.run, {e.req, " running"}, int'(err_running), e.run);
                check(int'(err_latched) == e.lat, {e.req, " latched"}, int'(err_latched), e.lat);
            end
        end
    end

    task automatic report();
        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R11: counts clear after reset
        check(err_running == '0, "R11 reset running", int'(err_running), 0);
        check(err_latched == '0, "R11 reset latched", int'(err_latched), 0);
        mon_on = 1'b1;

        // R2 R3: clean channel, encoder and alignment must agree
        cur_req = "R2 R3 clean"; nxt_period = 5;
        for (int i = 0; i < 24; i++) step(1'b1, 2'b00);

        // R1: random sign flips with noisy low bits
        cur_req = "R1 R4 random";
        for (int i = 0; i < 40; i++) step(1'b1, 2'($urandom_range(0, 3) & $urandom_range(0, 3)));

        // R10: stalls in between decoded bits
        cur_req = "R10 stall";
        for (int i = 0; i < 20; i++) step(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)));
        finish_period();

        // R5 R7: short periods, errors on every symbol
        cur_req = "R5 R7 period"; nxt_period = 3;
        for (int i = 0; i < 12; i++) step(1'b1, 2'b11);

        // R8: new length written mid-period, then 1 and 0
        cur_req = "R8 midperiod"; nxt_period = 7;
        step(1'b1, 2'b01);
        nxt_period = 4;
        for (int i = 0; i < 14; i++) step(1'b1, 2'b10);
        finish_period();
        nxt_period = 1;
        for (int i = 0; i < 4; i++) step(1'b1, 2'b11);
        nxt_period = 0;
        for (int i = 0; i < 4; i++) step(1'b1, 2'b01);

        // R9: every punctured rate, all signs flipped
        cur_req = "R9 puncture"; nxt_period = 12;
        for (int r = 1; r <= 7; r++) begin
            nxt_rate = r;
            finish_period();
            for (int i = 0; i < 30; i++) begin
                if (i == 5) nxt_rate = (r % 5) + 1;
                step(1'b1, 2'b11);
            end
        end
        nxt_rate = 0;
        finish_period();

        // R6: saturation over one long period
        cur_req = "R6 saturate"; nxt_period = 33000;
        step(1'b1, 2'b11);
        nxt_period = 5;
        for (int i = 1; i < 33000; i++) step(1'b1, 2'b11);
        step(1'b0, 2'b00);
        check(m_lat == 65535, "R6 model", m_lat, 65535);

        // R11: asynchronous clear mid-run
        @(negedge clk);
        mon_on = 1'b0;
        rst = 1'b1;
        #1;
        check(err_running == '0, "R11 async running", int'(err_running), 0);
        check(err_latched == '0, "R11 async latched", int'(err_latched), 0);
        report();
    end

endmodule